// File: doc/BRIEF.md
# Input Shift Register Unit

This unit carries out the shift-in operation of a small sequencer core. Each cycle in which the execute strobe is high, it decodes a 16-bit instruction word. If the word is a shift-in instruction, the unit takes a number of bits from one of several source words and moves them into a 32-bit input shift register (ISR). The direction of the shift comes from a configuration input that can change at run time. The unit also adds the number of bits moved to a shift counter, which saturates at the register width. A clear strobe empties the register and the counter.

Instructions arrive as single-cycle strobes, and the unit always accepts them. There is no valid/ready handshake and no back-pressure: a strobed instruction takes effect at the next clock edge. The unit never stalls the core. Emptying the register into a FIFO, autopush thresholds and delay or side-set timing belong to neighbouring logic.

Top module: `isr_shift_unit`

## Requirements
- R1: A state change happens only on a clock edge where `exec_en` is high and `instr[15:13]` equals 3'b010. Any other opcode, and any cycle without the strobe, leaves `isr_q` and `cnt_q` unchanged.
- R2: The field positions are fixed. `instr[7:5]` selects the source and `instr[4:0]` gives the bit count. `instr[12:8]` is the delay/side-set field, and its value has no effect on the result.
- R3: The source codes are: 3'b000 selects `pins`, 3'b001 selects `src_a`, 3'b010 selects `src_b`, 3'b110 selects the current ISR value, and 3'b111 selects `src_c`. Codes 3'b011, 3'b100 and 3'b101 supply an all-zero word.
- R4: When `shift_right` is 0 and N bits are shifted, the ISR becomes `(isr << N) | src[N-1:0]`.
- R5: When `shift_right` is 1 and N bits are shifted, the ISR becomes `(isr >> N) | (src[N-1:0] << (32-N))`.
- R6: A bit-count field of 0 means N = 32. A 32-bit shift replaces the ISR with the whole source word, in either direction.
- R7: Each executed shift-in adds N to `cnt_q`, and the result saturates at 32. This applies to zero-source codes too.
- R8: When `clear` is high, both `isr_q` and `cnt_q` become 0 at the next edge. The clear wins over an execute in the same cycle.
- R9: After reset, `isr_q` is 0 and `cnt_q` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 16 | Instruction word |
| exec_en | input | 1 | Execute strobe for `instr` |
| pins | input | 32 | Input pin vector (source 000) |
| src_a | input | 32 | Source word for code 001 |
| src_b | input | 32 | Source word for code 010 |
| src_c | input | 32 | Source word for code 111 |
| shift_right | input | 1 | 1 shifts right, 0 shifts left |
| clear | input | 1 | Empties the ISR and the counter |
| isr_q | output | 32 | ISR contents |
| cnt_q | output | 6 | Saturating shift count, 0 to 32 |

## Verification
The bench builds the unit with its default width of 32. At this width the 5-bit count field covers every shift length, and a field value of 0 stands for a full-width shift, so every one of the 32 possible lengths can be reached. Saturation is reached after only two or three random executes, which means random sequences often cross the 32 limit. The bench also mixes the direction bit, unused source codes and non-matching opcodes between successive executes.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int unsigned OPC_HI = 15;
  localparam int unsigned OPC_LO = 13;
  localparam logic [2:0]  OPC_SHIFT_IN = 3'b010;

  typedef enum logic [2:0] {
    SRC_PINS  = 3'b000,
    SRC_A     = 3'b001,
    SRC_B     = 3'b010,
    SRC_ZERO0 = 3'b011,
    SRC_ZERO1 = 3'b100,
    SRC_ZERO2 = 3'b101,
    SRC_SELF  = 3'b110,
    SRC_C     = 3'b111
  } src_sel_e;

  typedef struct packed {
    logic       hit;
    logic [4:0] dly;
    src_sel_e   sel;
    logic [4:0] cnt_field;
  } instr_dec_t;
endpackage

// File: rtl/isr_decode.sv
module isr_decode
  import isr_pkg::*;
#(
  parameter int unsigned W    = 32,
  localparam int unsigned CNTW = $clog2(W) + 1
) (
  input  logic [15:0]     instr,
  input  logic            exec_en,
  output instr_dec_t      dec,
  output logic [CNTW-1:0] nbits
);
  always_comb begin
    dec.hit       = exec_en && (instr[OPC_HI:OPC_LO] == OPC_SHIFT_IN);
    dec.dly       = instr[12:8];
    dec.sel       = src_sel_e'(instr[7:5]);
    dec.cnt_field = instr[4:0];
    nbits = (instr[4:0] == 5'd0) ? CNTW'(W) : CNTW'(instr[4:0]);
  end
endmodule

// File: rtl/isr_src_mux.sv
module isr_src_mux
  import isr_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  src_sel_e     sel,
  input  logic [W-1:0] pins,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  input  logic [W-1:0] src_c,
  input  logic [W-1:0] isr_cur,
  output logic [W-1:0] word
);
  always_comb begin
    unique case (sel)
      SRC_PINS: word = pins;
      SRC_A:    word = src_a;
      SRC_B:    word = src_b;
      SRC_SELF: word = isr_cur;
      SRC_C:    word = src_c;
      default:  word = '0;
    endcase
  end
endmodule

// File: rtl/isr_shifter.sv
module isr_shifter #(
  parameter int unsigned W    = 32,
  localparam int unsigned CNTW = $clog2(W) + 1
) (
  input  logic [W-1:0]    cur,
  input  logic [W-1:0]    src,
  input  logic [CNTW-1:0] nbits,
  input  logic            right,
  output logic [W-1:0]    nxt
);
  logic [CNTW-1:0] gap;
  logic [W-1:0]    keep_mask;
  logic [W-1:0]    low_bits;

  always_comb begin
    gap       = CNTW'(W) - nbits;
    keep_mask = {W{1'b1}} >> gap;
    low_bits  = src & keep_mask;
    if (right) nxt = (cur >> nbits) | (low_bits << gap);
    else       nxt = (cur << nbits) | low_bits;
  end
endmodule

// File: rtl/isr_shift_unit.sv
module isr_shift_unit
  import isr_pkg::*;
#(
  parameter int unsigned W    = 32,
  localparam int unsigned CNTW = $clog2(W) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [15:0]     instr,
  input  logic            exec_en,
  input  logic [W-1:0]    pins,
  input  logic [W-1:0]    src_a,
  input  logic [W-1:0]    src_b,
  input  logic [W-1:0]    src_c,
  input  logic            shift_right,
  input  logic            clear,
  output logic [W-1:0]    isr_q,
  output logic [CNTW-1:0] cnt_q
);
  instr_dec_t      dec;
  logic [CNTW-1:0] nbits;
  logic [W-1:0]    src_word;
  logic [W-1:0]    isr_next;
  logic [CNTW:0]   cnt_sum;
  logic [CNTW-1:0] cnt_next;

  isr_decode #(.W(W)) dec_i (
    .instr(instr), .exec_en(exec_en), .dec(dec), .nbits(nbits)
  );

  isr_src_mux #(.W(W)) mux_i (
    .sel(dec.sel), .pins(pins), .src_a(src_a), .src_b(src_b),
    .src_c(src_c), .isr_cur(isr_q), .word(src_word)
  );

  isr_shifter #(.W(W)) shf_i (
    .cur(isr_q), .src(src_word), .nbits(nbits), .right(shift_right),
    .nxt(isr_next)
  );

  always_comb begin
    cnt_sum  = {1'b0, cnt_q} + {1'b0, nbits};
    cnt_next = (cnt_sum > (CNTW+1)'(W)) ? CNTW'(W) : cnt_sum[CNTW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= '0;
      cnt_q <= '0;
    end else if (clear) begin
      isr_q <= '0;
      cnt_q <= '0;
    end else if (dec.hit) begin
      isr_q <= isr_next;
      cnt_q <= cnt_next;
    end
  end
endmodule

// File: rtl/isr_shift_unit_chk.sv
module isr_shift_unit_chk #(
  parameter int unsigned W    = 32,
  localparam int unsigned CNTW = $clog2(W) + 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [15:0]     instr,
  input logic            exec_en,
  input logic [W-1:0]    pins,
  input logic            shift_right,
  input logic            clear,
  input logic [W-1:0]    isr_q,
  input logic [CNTW-1:0] cnt_q
);
  logic go;
  assign go = exec_en && instr[15:13] == 3'b010 && !clear;

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !go) |=> ($stable(isr_q) && $stable(cnt_q)));

  p_full_replace_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (go && instr[7:0] == 8'h00) |=> (isr_q == $past(pins)));

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNTW'(W));

  p_cnt_grows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (cnt_q > $past(cnt_q) || cnt_q == CNTW'(W)));

  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (isr_q == '0 && cnt_q == '0));
endmodule

bind isr_shift_unit isr_shift_unit_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .instr(instr), .exec_en(exec_en),
  .pins(pins), .shift_right(shift_right), .clear(clear),
  .isr_q(isr_q), .cnt_q(cnt_q)
);

// File: tb/isr_shift_unit_tb_top.sv
module isr_shift_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr = '0;
  logic        exec_en = 1'b0;
  logic [31:0] pins = '0, src_a = '0, src_b = '0, src_c = '0;
  logic        shift_right = 1'b0;
  logic        clear = 1'b0;
  logic [31:0] isr_q;
  logic [5:0]  cnt_q;

  int total = 0;
  int bad = 0;
  logic [31:0] m_isr = '0;
  int          m_cnt = 0;

  always #4 clk = ~clk;

  isr_shift_unit dut_i (
    .clk(clk), .rst_n(rst_n), .instr(instr), .exec_en(exec_en),
    .pins(pins), .src_a(src_a), .src_b(src_b), .src_c(src_c),
    .shift_right(shift_right), .clear(clear), .isr_q(isr_q), .cnt_q(cnt_q)
  );

  function automatic logic [31:0] pick(logic [2:0] s, logic [31:0] cur);
    case (s)
      3'b000: return pins;
      3'b001: return src_a;
      3'b010: return src_b;
      3'b110: return cur;
      3'b111: return src_c;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] shift_model(logic [31:0] cur, logic [31:0] s,
                                              int n, logic rt);
    logic [31:0] v = cur;
    if (rt) for (int i = 0; i < n; i++) v = {s[i], v[31:1]};
    else    for (int i = n - 1; i >= 0; i--) v = {v[30:0], s[i]};
    return v;
  endfunction

  task automatic check(string req);
    total++;
    if (isr_q !== m_isr || cnt_q !== 6'(m_cnt)) begin
      bad++;
      $display("FAIL %s isr=%h cnt=%0d expected isr=%h cnt=%0d",
               req, isr_q, cnt_q, m_isr, m_cnt);
    end
  endtask

  // drive at negedge, apply one edge, model it, check at next negedge
  task automatic step(logic [15:0] ins, logic ex, logic rt, logic clr, string req);
    int n;
    instr = ins; exec_en = ex; shift_right = rt; clear = clr;
    if (clr) begin
      m_isr = '0; m_cnt = 0;
    end else if (ex && ins[15:13] == 3'b010) begin
      n = (ins[4:0] == 0) ? 32 : int'(ins[4:0]);
      m_isr = shift_model(m_isr, pick(ins[7:5], m_isr), n, rt);
      m_cnt = (m_cnt + n > 32) ? 32 : m_cnt + n;
    end
    @(posedge clk);
    @(negedge clk);
    check(req);
    exec_en = 1'b0; clear = 1'b0;
  endtask

  function automatic logic [15:0] op(logic [4:0] dly, logic [2:0] s, logic [4:0] n);
    return {3'b010, dly, s, n};
  endfunction

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (2) @(negedge clk);
    check("R9 reset");
    rst_n = 1'b1;
    @(negedge clk);
    pins = 32'hA5A5_0F0F; src_a = 32'h1234_5678; src_b = 32'hCAFE_F00D; src_c = 32'h8000_0001;
    step(op(5'd0, 3'b000, 5'd4), 1'b1, 1'b0, 1'b0, "R4 left 4 pins");
    step(op(5'd0, 3'b001, 5'd8), 1'b1, 1'b1, 1'b0, "R5 right 8 src_a");
    step(op(5'd31, 3'b010, 5'd3), 1'b1, 1'b0, 1'b0, "R2 delay field ignored");
    step(op(5'd0, 3'b011, 5'd5), 1'b1, 1'b0, 1'b0, "R3 zero code 011");
    step(op(5'd0, 3'b110, 5'd7), 1'b1, 1'b1, 1'b0, "R3 self source");
    step(op(5'd0, 3'b111, 5'd9), 1'b1, 1'b0, 1'b0, "R7 saturation");
    step({3'b011, 13'h0FFF}, 1'b1, 1'b0, 1'b0, "R1 other opcode");
    step(op(5'd0, 3'b000, 5'd2), 1'b0, 1'b0, 1'b0, "R1 no strobe");
    step(op(5'd0, 3'b000, 5'd4), 1'b1, 1'b0, 1'b1, "R8 clear beats exec");
    step(op(5'd0, 3'b000, 5'd0), 1'b1, 1'b1, 1'b0, "R6 full replace right");
    step(op(5'd0, 3'b111, 5'd0), 1'b1, 1'b0, 1'b0, "R6 full replace left");
    step(op(5'd0, 3'b101, 5'd1), 1'b1, 1'b0, 1'b0, "R3 zero code 101 R7 held");
    for (int k = 0; k < 3000; k++) begin
      logic [15:0] ins;
      pins = $urandom; src_a = $urandom; src_b = $urandom; src_c = $urandom;
      ins = $urandom;
      if ($urandom_range(3) != 0) ins[15:13] = 3'b010;
      step(ins, $urandom_range(7) != 0, $urandom_range(1) == 1,
           $urandom_range(15) == 0, "R4 R5 R7 random");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule